// File: doc/BRIEF.md
# Reset Control Port Sequencer

This block decodes a single byte-wide I/O port that software uses to request a platform reset, and produces the timed reset pulses that follow such a request. A write that sets the command bit launches one of three sequences. The first is a short processor initialisation pulse. The second is a full reset that drives the bus reset and the processor reset together. The third is a full reset that first holds the platform in a soft-off state and then drives both resets. The type of sequence comes from the mode bits carried in that same write.

Two hardware events can also start a full reset. One is a loss of power-good. The other is a watchdog second timeout while rebooting is allowed. For these, the stored soft-off bit decides whether the soft-off phase runs first.

All durations are counted on the block clock and set by parameters. The defaults assume a 33 MHz clock. A busy flag covers the whole of a running sequence, and any new trigger that arrives while it is set is dropped.

Top module: `rstctl_seq`

## Requirements
- R1: After reset the stored byte is 00h. A read returns the stored values of bit 3 (soft-off select) and bit 1 (full-reset select), with bit 2 and bits 7..4 and 0 always 0. Read data appears on the clock edge after the edge that samples the read and is 0 in every cycle without a decoded read.
- R2: The port is decoded only when `port_en` is high and `io_addr` equals PORT_ADDR (default 0CF9h). A write in any other case has no effect on outputs or stored bits. A read in any other case returns 0.
- R3: A decoded write with bit 2 = 1 and bit 1 = 0 drives `init_out` high for exactly INIT_CYC cycles (default 16). It rises on the second rising edge after the edge that samples the write.
- R4: A decoded write with bit 2 = 1, bit 1 = 1 and bit 3 = 0 drives `pci_rst_out` and `cpu_rst_out` together high for exactly FULL_CYC cycles, with the same start latency as R3. The two outputs are always equal.
- R5: A decoded write with bits 3, 2 and 1 all = 1 drives `soft_off_out` high for SOFF_CYC cycles. Both resets are high for SOFF_CYC + FULL_CYC cycles starting in the same cycle. `soft_off_out` is never high without both resets.
- R6: The sequence type uses bits 3 and 1 of the write that carries the command, not the previously stored bits. Bit 3 has no effect when bit 1 = 0. Reserved bits have no effect. A write with bit 2 = 0 starts nothing but still stores bits 3 and 1.
- R7: A high-to-low transition of `pwr_good` starts a full reset, with a soft-off phase only if the stored bit 3 is 1. It starts two edges after the sampling edge. A low-to-high transition starts nothing.
- R8: A rise of the condition `wdt_timeout` high with `no_reboot` low starts a full reset that uses the stored bit 3. Holding the condition high does not start another. With `no_reboot` high the watchdog input starts nothing.
- R9: `busy` is high in exactly the cycles in which any sequence output is high. Commands and events that arrive while `busy` is high are dropped, but the write still updates the stored bits.
- R10: `init_out` is never high together with either reset output or with `soft_off_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the duration reference |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Enables decoding of the port |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Registered read data |
| pwr_good | input | 1 | Power-good level |
| wdt_timeout | input | 1 | Watchdog second-timeout status |
| no_reboot | input | 1 | High blocks watchdog-started resets |
| init_out | output | 1 | Processor initialisation pulse, active high |
| pci_rst_out | output | 1 | Bus reset, active high |
| cpu_rst_out | output | 1 | Processor reset, active high |
| soft_off_out | output | 1 | Soft-off hold request, active high |
| busy | output | 1 | A sequence is running |

## Verification
The write or event is registered on the edge that samples it, and the sequencer output registers respond on the next edge. Every pulse therefore rises two edges after the stimulus, while read data lands one edge after the read. The bench drives on falling edges and samples on every falling edge after the stimulus. For each output it records the first sample index at which the output is high, which must be 2, and it counts the high samples to compare with the parameter-derived widths. Overlapping triggers are driven part-way into a running sequence, and the resulting widths are compared with those of the undisturbed case.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  // bit positions inside the control byte (decoded by the sequencer)
  localparam int unsigned FULL_BIT = 1;
  localparam int unsigned CMD_BIT  = 2;
  localparam int unsigned SOFF_BIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_SOFF = 2'd2,
    ST_RST  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic soff;
    logic full;
  } rst_mode_t;

endpackage

// File: rtl/rstctl_regif.sv
module rstctl_regif
  import rstctl_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 16,
  parameter int unsigned        DATA_W    = 8,
  parameter logic [ADDR_W-1:0]  PORT_ADDR = 16'h0CF9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              cmd_go,
  output rst_mode_t         cmd_mode,
  output rst_mode_t         keep_mode
);

  logic              hit;
  logic [DATA_W-1:0] rb_vec;
  logic              unused_wbits;

  assign hit          = port_en && (io_addr == PORT_ADDR);
  assign unused_wbits = ^io_wdata;

  // read-back image: only the two stored mode bits are visible
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rb
      if (i == FULL_BIT) begin : g_full
        assign rb_vec[i] = keep_mode.full;
      end else if (i == SOFF_BIT) begin : g_soff
        assign rb_vec[i] = keep_mode.soff;
      end else begin : g_zero
        assign rb_vec[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_mode <= '0;
      cmd_mode  <= '0;
      cmd_go    <= 1'b0;
      io_rdata  <= '0;
    end else begin
      cmd_go   <= hit && io_wr && io_wdata[CMD_BIT];
      io_rdata <= (hit && io_rd) ? rb_vec : '0;
      if (hit && io_wr) begin
        keep_mode.full <= io_wdata[FULL_BIT];
        keep_mode.soff <= io_wdata[SOFF_BIT];
        cmd_mode.full  <= io_wdata[FULL_BIT];
        cmd_mode.soff  <= io_wdata[SOFF_BIT];
      end
    end
  end

endmodule

// File: rtl/rstctl_trig.sv
module rstctl_trig (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic wdt_timeout,
  input  logic no_reboot,
  output logic ext_go
);

  logic pg_q;
  logic wd_q;
  logic wd_cond;

  assign wd_cond = wdt_timeout && !no_reboot;

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q   <= pwr_good;
      wd_q   <= wd_cond;
      ext_go <= 1'b0;
    end else begin
      pg_q   <= pwr_good;
      wd_q   <= wd_cond;
      ext_go <= (pg_q && !pwr_good) || (wd_cond && !wd_q);
    end
  end

endmodule

// File: rtl/rstctl_fsm.sv
module rstctl_fsm
  import rstctl_pkg::*;
#(
  parameter int unsigned INIT_CYC = 16,
  parameter int unsigned FULL_CYC = 57750,
  parameter int unsigned SOFF_CYC = 132000000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_go,
  input  rst_mode_t cmd_mode,
  input  logic      ext_go,
  input  rst_mode_t keep_mode,
  output logic      init_out,
  output logic      pci_rst_out,
  output logic      cpu_rst_out,
  output logic      soft_off_out,
  output logic      busy
);

  localparam int unsigned MAX_A = (INIT_CYC > FULL_CYC) ? INIT_CYC : FULL_CYC;
  localparam int unsigned MAX_C = (MAX_A > SOFF_CYC) ? MAX_A : SOFF_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] INIT_LD = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] FULL_LD = CNT_W'(FULL_CYC - 1);
  localparam logic [CNT_W-1:0] SOFF_LD = CNT_W'(SOFF_CYC - 1);

  seq_state_e       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    unique case (st)
      ST_IDLE: begin
        if (cmd_go) begin
          if (!cmd_mode.full) begin
            st_n  = ST_INIT;
            cnt_n = INIT_LD;
          end else if (cmd_mode.soff) begin
            st_n  = ST_SOFF;
            cnt_n = SOFF_LD;
          end else begin
            st_n  = ST_RST;
            cnt_n = FULL_LD;
          end
        end else if (ext_go) begin
          if (keep_mode.soff) begin
            st_n  = ST_SOFF;
            cnt_n = SOFF_LD;
          end else begin
            st_n  = ST_RST;
            cnt_n = FULL_LD;
          end
        end
      end
      ST_INIT: begin
        if (cnt_zero) st_n = ST_IDLE;
        else          cnt_n = cnt - 1'b1;
      end
      ST_SOFF: begin
        if (cnt_zero) begin
          st_n  = ST_RST;
          cnt_n = FULL_LD;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_RST: begin
        if (cnt_zero) st_n = ST_IDLE;
        else          cnt_n = cnt - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cnt          <= '0;
      init_out     <= 1'b0;
      pci_rst_out  <= 1'b0;
      cpu_rst_out  <= 1'b0;
      soft_off_out <= 1'b0;
      busy         <= 1'b0;
    end else begin
      st           <= st_n;
      cnt          <= cnt_n;
      init_out     <= (st_n == ST_INIT);
      pci_rst_out  <= (st_n == ST_SOFF) || (st_n == ST_RST);
      cpu_rst_out  <= (st_n == ST_SOFF) || (st_n == ST_RST);
      soft_off_out <= (st_n == ST_SOFF);
      busy         <= (st_n != ST_IDLE);
    end
  end

endmodule

// File: rtl/rstctl_seq.sv
module rstctl_seq
  import rstctl_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 16,
  parameter int unsigned        DATA_W    = 8,
  parameter logic [ADDR_W-1:0]  PORT_ADDR = 16'h0CF9,
  parameter int unsigned        INIT_CYC  = 16,
  parameter int unsigned        FULL_CYC  = 57750,
  parameter int unsigned        SOFF_CYC  = 132000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              pwr_good,
  input  logic              wdt_timeout,
  input  logic              no_reboot,
  output logic              init_out,
  output logic              pci_rst_out,
  output logic              cpu_rst_out,
  output logic              soft_off_out,
  output logic              busy
);

  logic      cmd_go;
  logic      ext_go;
  rst_mode_t cmd_mode;
  rst_mode_t keep_mode;

  rstctl_regif #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PORT_ADDR (PORT_ADDR)
  ) u_regif (
    .clk       (clk),
    .rst       (rst),
    .port_en   (port_en),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .cmd_go    (cmd_go),
    .cmd_mode  (cmd_mode),
    .keep_mode (keep_mode)
  );

  rstctl_trig u_trig (
    .clk         (clk),
    .rst         (rst),
    .pwr_good    (pwr_good),
    .wdt_timeout (wdt_timeout),
    .no_reboot   (no_reboot),
    .ext_go      (ext_go)
  );

  rstctl_fsm #(
    .INIT_CYC (INIT_CYC),
    .FULL_CYC (FULL_CYC),
    .SOFF_CYC (SOFF_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cmd_go       (cmd_go),
    .cmd_mode     (cmd_mode),
    .ext_go       (ext_go),
    .keep_mode    (keep_mode),
    .init_out     (init_out),
    .pci_rst_out  (pci_rst_out),
    .cpu_rst_out  (cpu_rst_out),
    .soft_off_out (soft_off_out),
    .busy         (busy)
  );

endmodule

// File: rtl/rstctl_seq_chk.sv
module rstctl_seq_chk
  import rstctl_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9,
  parameter int unsigned       INIT_CYC  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              port_en,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_rdata,
  input logic              init_out,
  input logic              pci_rst_out,
  input logic              cpu_rst_out,
  input logic              soft_off_out,
  input logic              busy
);

  int unsigned init_run;

  always_ff @(posedge clk) begin
    if (rst)           init_run <= 0;
    else if (init_out) init_run <= init_run + 1;
    else               init_run <= 0;
  end

  // R1
  rb_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    io_rdata[CMD_BIT] == 1'b0);

  // R2
  no_hit_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(port_en && io_rd && io_addr == PORT_ADDR) |=> io_rdata == '0);

  // R3
  init_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(init_out) |-> init_run == INIT_CYC);

  // R3
  init_cap_chk: assert property (@(posedge clk) disable iff (rst)
    init_run <= INIT_CYC);

  // R4
  rst_pair_chk: assert property (@(posedge clk) disable iff (rst)
    pci_rst_out == cpu_rst_out);

  // R5
  soff_rst_chk: assert property (@(posedge clk) disable iff (rst)
    soft_off_out |-> (pci_rst_out && cpu_rst_out));

  // R9
  busy_match_chk: assert property (@(posedge clk) disable iff (rst)
    busy == (init_out || pci_rst_out || soft_off_out));

  // R10
  init_excl_chk: assert property (@(posedge clk) disable iff (rst)
    init_out |-> !(pci_rst_out || cpu_rst_out || soft_off_out));

endmodule

bind rstctl_seq rstctl_seq_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PORT_ADDR (PORT_ADDR),
  .INIT_CYC  (INIT_CYC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .port_en      (port_en),
  .io_addr      (io_addr),
  .io_rd        (io_rd),
  .io_rdata     (io_rdata),
  .init_out     (init_out),
  .pci_rst_out  (pci_rst_out),
  .cpu_rst_out  (cpu_rst_out),
  .soft_off_out (soft_off_out),
  .busy         (busy)
);

// File: tb/rstctl_seq_tb.sv
module rstctl_seq_tb;

  localparam int INIT_C = 16;
  localparam int FULL_C = 40;
  localparam int SOFF_C = 60;
  localparam logic [15:0] PADDR = 16'h0CF9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_en = 1'b1;
  logic [15:0] io_addr = PADDR;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        pwr_good = 1'b1;
  logic        wdt_timeout = 1'b0;
  logic        no_reboot = 1'b1;
  logic        init_out, pci_rst_out, cpu_rst_out, soft_off_out, busy;

  always #10 clk = ~clk;

  rstctl_seq #(
    .INIT_CYC (INIT_C),
    .FULL_CYC (FULL_C),
    .SOFF_CYC (SOFF_C)
  ) u_dut (
    .clk(clk), .rst(rst), .port_en(port_en), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pwr_good(pwr_good), .wdt_timeout(wdt_timeout), .no_reboot(no_reboot),
    .init_out(init_out), .pci_rst_out(pci_rst_out), .cpu_rst_out(cpu_rst_out),
    .soft_off_out(soft_off_out), .busy(busy)
  );

  // {wdata, init width, reset width, soft-off width, read-back}
  localparam logic [39:0] VEC [7] = '{
    {8'h0A, 8'd0,  8'd0,   8'd0,  8'h0A},
    {8'h04, 8'd16, 8'd0,   8'd0,  8'h00},
    {8'h06, 8'd0,  8'd40,  8'd0,  8'h02},
    {8'h0E, 8'd0,  8'd100, 8'd60, 8'h0A},
    {8'h0C, 8'd16, 8'd0,   8'd0,  8'h08},
    {8'hF4, 8'd16, 8'd0,   8'd0,  8'h00},
    {8'hF6, 8'd0,  8'd40,  8'd0,  8'h02}
  };

  int checks = 0;
  int errors = 0;
  int n_init, n_rst, n_soff, n_busy, n_pair_bad;
  int f_init, f_rst, f_soff, tick;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    n_init = 0; n_rst = 0; n_soff = 0; n_busy = 0; n_pair_bad = 0;
    f_init = -1; f_rst = -1; f_soff = -1; tick = 0;
  endtask

  task automatic observe(input int ncyc);
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      tick++;
      io_wr = 1'b0;
      io_rd = 1'b0;
      if (init_out) begin n_init++; if (f_init < 0) f_init = tick; end
      if (pci_rst_out) begin n_rst++; if (f_rst < 0) f_rst = tick; end
      if (soft_off_out) begin n_soff++; if (f_soff < 0) f_soff = tick; end
      if (busy) n_busy++;
      if (pci_rst_out != cpu_rst_out) n_pair_bad++;
    end
  endtask

  task automatic write_io(input logic [15:0] a, input logic [7:0] d);
    io_addr  = a;
    io_wdata = d;
    io_wr    = 1'b1;
  endtask

  task automatic read_io(output int v);
    io_addr = PADDR;
    io_rd   = 1'b1;
    @(negedge clk);
    v = int'(io_rdata);
    io_rd = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL all: watchdog expired, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rv;
    logic [39:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 reset outputs", int'({init_out, pci_rst_out, cpu_rst_out, soft_off_out, busy}), 0);
    read_io(rv);
    check("R1 reset readback", rv, 0);

    // R3 R4 R5 R6 table walk
    for (int i = 0; i < 7; i++) begin
      v = VEC[i];
      clear_obs();
      write_io(PADDR, v[39:32]);
      observe(130);
      check("R3 R6 init width", n_init, int'(v[31:24]));
      check("R4 R6 reset width", n_rst, int'(v[23:16]));
      check("R5 R6 soft-off width", n_soff, int'(v[15:8]));
      check("R4 reset pair", n_pair_bad, 0);
      check("R9 busy width", n_busy, (n_init > n_rst) ? n_init : n_rst);
      if (v[31:24] != 0) check("R3 init start", f_init, 2);
      if (v[23:16] != 0) check("R4 reset start", f_rst, 2);
      if (v[15:8]  != 0) check("R5 soft-off start", f_soff, 2);
      read_io(rv);
      check("R1 readback", rv, int'(v[7:0]));
    end

    // R2 disabled port and wrong address
    port_en = 1'b0;
    clear_obs();
    write_io(PADDR, 8'h06);
    observe(60);
    check("R2 disabled write", n_rst + n_init, 0);
    read_io(rv);
    check("R2 disabled read", rv, 0);
    port_en = 1'b1;
    clear_obs();
    write_io(16'h0CF8, 8'h0E);
    observe(60);
    check("R2 wrong address write", n_rst + n_init + n_soff, 0);
    read_io(rv);
    check("R2 stored bits kept", rv, 8'h02);

    // R9 command during a running sequence is dropped
    clear_obs();
    write_io(PADDR, 8'h06);
    observe(10);
    write_io(PADDR, 8'h04);
    observe(100);
    check("R9 dropped init", n_init, 0);
    check("R9 reset width unchanged", n_rst, FULL_C);
    check("R9 busy span", n_busy, FULL_C);
    read_io(rv);
    check("R9 bits stored while busy", rv, 0);

    // R7 power-good loss with stored soft-off
    write_io(PADDR, 8'h08);
    observe(3);
    clear_obs();
    pwr_good = 1'b0;
    observe(130);
    check("R7 soft-off width", n_soff, SOFF_C);
    check("R7 reset width", n_rst, SOFF_C + FULL_C);
    check("R7 start", f_rst, 2);
    clear_obs();
    pwr_good = 1'b1;
    observe(20);
    check("R7 rise ignored", n_rst + n_init, 0);
    write_io(PADDR, 8'h00);
    observe(3);
    clear_obs();
    pwr_good = 1'b0;
    observe(80);
    check("R7 plain full", n_rst, FULL_C);
    check("R7 no soft-off", n_soff, 0);
    pwr_good = 1'b1;
    observe(3);

    // R8 watchdog
    clear_obs();
    wdt_timeout = 1'b1;
    observe(60);
    check("R8 blocked by no_reboot", n_rst + n_init, 0);
    wdt_timeout = 1'b0;
    observe(3);
    no_reboot = 1'b0;
    clear_obs();
    wdt_timeout = 1'b1;
    observe(80);
    check("R8 watchdog reset", n_rst, FULL_C);
    check("R8 start", f_rst, 2);
    check("R10 no init during reset", n_init, 0);
    clear_obs();
    observe(60);
    check("R8 held level no repeat", n_rst, 0);
    wdt_timeout = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule